// File: doc/BRIEF.md
# Snooping MESI Line State Controller

This block holds the coherence state and tag of every line of a small direct-mapped cache and keeps both up to date from two directions. The local processor issues reads and writes through a request port. The block answers hits at once, and for a miss or an upgrade it raises a request on a bus-issue port and waits for a grant. A snoop port carries the transactions that other agents place on the shared bus: reads, intent-to-write requests and plain writes such as those from a DMA engine. The block reacts to each of these by lowering the line state, and it flags intervention and write-back when it holds the only dirty copy.

The data array, the memory, and the bus arbiter all sit outside the block. Addresses on all ports are line addresses: the low `IDX_W` bits select the line and the remaining bits form the tag. When a miss would evict a Modified line, the block first asks the bus to write that victim back, and only then asks for the new line.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is 1, and `bus_valid`, `cpu_done`, `snp_intervene` and `snp_writeback` are 0.
- R2: `cpu_state` reports a line state with the codes Invalid=0, Shared=1, Exclusive=2, Modified=3. It is valid while `cpu_done` is 1. `cpu_done` pulses in the cycle after a request completes.
- R3: A read miss raises `bus_valid` with `bus_op`=0 (read) and the requested line address. On the grant, the line becomes Shared if `bus_shared` is 1 and Exclusive if it is 0.
- R4: A write miss, or a write to a Shared line, raises `bus_valid` with `bus_op`=1 (intent-to-write) and the requested address. On the grant, the line becomes Modified.
- R5: A read hit in any valid state and a write hit in Exclusive or Modified complete in the cycle after acceptance with no bus request. The read leaves the state unchanged, and the write leaves the line Modified.
- R6: On a snooped read (`snp_op`=0) that hits a Modified line, the block asserts `snp_intervene` and `snp_writeback` for one cycle in the cycle after the snoop, and the line becomes Shared. An Exclusive line silently becomes Shared, and a Shared line is untouched.
- R7: On a snooped intent-to-write (`snp_op`=1) that hits a valid line, the line becomes Invalid. If the line was Modified, both `snp_intervene` and `snp_writeback` pulse.
- R8: On a snooped plain write (`snp_op`=2), a Shared or Exclusive line is purged to Invalid with no pulse. A Modified line pulses `snp_writeback` only and becomes Invalid.
- R9: A snoop whose tag differs from the tag stored at its index has no effect on the line and raises no pulse.
- R10: When a processor request and a snoop address the same line in the same cycle, the snoop takes effect first, and the request sees the resulting state.
- R11: A miss that would replace a Modified line with a different tag first raises `bus_op`=2 (write-back) with the victim's address. After that grant the victim is Invalid, and the fill request follows in the next cycle.
- R12: `cpu_valid` is ignored while `cpu_ready` is 0. Only one request is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request strobe, taken when cpu_ready is 1 |
| cpu_write | input | 1 | 1 = write request, 0 = read request |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_ready | output | 1 | Block is idle and accepts a request |
| cpu_done | output | 1 | Request finished (one-cycle pulse) |
| cpu_state | output | 2 | Line state after the finished request |
| bus_valid | output | 1 | Bus request pending |
| bus_op | output | 2 | 0 read, 1 intent-to-write, 2 write-back |
| bus_addr | output | ADDR_W | Line address of the bus request |
| bus_gnt | input | 1 | Bus grant for the pending request |
| bus_shared | input | 1 | Another cache holds the line (sampled with a read grant) |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_op | input | 2 | 0 read, 1 intent-to-write, 2 plain write, 3 no effect |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_intervene | output | 1 | This cache supplies the snooped line |
| snp_writeback | output | 1 | This cache must write the dirty line back |

## Verification
The bench builds the block with `IDX_W`=2 and `ADDR_W`=10, which gives four lines and eight tag bits. With only four lines, tag conflicts at one index come up in a handful of requests. That brings dirty-victim eviction, snoops that miss on the tag, and same-line collisions between a snoop and a processor request within reach of a short directed sequence. Every state is observed at the ports: after each snoop, a processor read of the same line either completes as a hit that reports the state or turns into a bus read that shows the line was purged.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BOP_RD  = 2'd0,
        BOP_RDX = 2'd1,
        BOP_WB  = 2'd2,
        BOP_NIL = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        SOP_RD  = 2'd0,
        SOP_RDX = 2'd1,
        SOP_WR  = 2'd2,
        SOP_NOP = 2'd3
    } snp_op_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_WB   = 2'd1,
        F_REQ  = 2'd2
    } fsm_e;

    typedef struct packed {
        logic     hit;
        logic     intervene;
        logic     writeback;
        line_st_e nxt;
    } snp_act_t;

    // Valid bit of the state encoding: everything except Invalid.
    function automatic logic st_valid(line_st_e s);
        return s != ST_I;
    endfunction

    // Dirty bit: only Modified holds data newer than memory.
    function automatic logic st_dirty(line_st_e s);
        return s == ST_M;
    endfunction

    // Reaction of one line to one observed bus transaction.
    function automatic snp_act_t snoop_rule(line_st_e cur, logic match, snp_op_e op);
        snp_act_t a;
        a.hit       = match;
        a.intervene = 1'b0;
        a.writeback = 1'b0;
        a.nxt       = cur;
        if (match) begin
            case (op)
                SOP_RD: begin
                    if (st_dirty(cur)) begin
                        a.nxt       = ST_S;
                        a.intervene = 1'b1;
                        a.writeback = 1'b1;
                    end else if (cur == ST_E) begin
                        a.nxt = ST_S;
                    end
                end
                SOP_RDX: begin
                    a.nxt       = ST_I;
                    a.intervene = st_dirty(cur);
                    a.writeback = st_dirty(cur);
                end
                SOP_WR: begin
                    a.nxt       = ST_I;
                    a.writeback = st_dirty(cur);
                end
                default: a.hit = 1'b0;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    output line_st_e         a_st,
    output logic [TAG_W-1:0] a_tag,
    input  logic [IDX_W-1:0] b_idx,
    output line_st_e         b_st,
    output logic [TAG_W-1:0] b_tag,
    input  logic             s_we,
    input  logic [IDX_W-1:0] s_idx,
    input  line_st_e         s_st,
    input  logic             c_we,
    input  logic [IDX_W-1:0] c_idx,
    input  logic [TAG_W-1:0] c_tag,
    input  line_st_e         c_st
);
    localparam int LINES = 1 << IDX_W;

    line_st_e         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    // The processor-side write already includes any same-cycle snoop effect,
    // so it takes priority over the snoop write at the same index.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (rst) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
            end else if (c_we && c_idx == IDX_W'(i)) begin
                st_q[i]  <= c_st;
                tag_q[i] <= c_tag;
            end else if (s_we && s_idx == IDX_W'(i)) begin
                st_q[i] <= s_st;
            end
        end
    end

    assign a_st  = st_q[a_idx];
    assign a_tag = tag_q[a_idx];
    assign b_st  = st_q[b_idx];
    assign b_tag = tag_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             snp_valid,
    input  snp_op_e          snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output snp_act_t         act
);
    logic match;

    always_comb begin
        match = snp_valid && st_valid(line_st) && (line_tag == snp_tag);
        act   = snoop_rule(line_st, match, snp_op);
    end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_valid,
    input  logic             cpu_write,
    input  logic [TAG_W-1:0] cpu_tag,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic [IDX_W-1:0] look_idx,
    input  line_st_e         eff_st,
    input  logic [TAG_W-1:0] eff_tag,
    input  logic             bus_gnt,
    input  logic             bus_shared,
    output logic             cpu_ready,
    output logic             cpu_done,
    output line_st_e         done_st,
    output logic             bus_valid,
    output bus_op_e          bus_op,
    output logic [TAG_W-1:0] bus_tag,
    output logic [IDX_W-1:0] bus_idx,
    output logic             c_we,
    output logic [IDX_W-1:0] c_idx,
    output logic [TAG_W-1:0] c_tag,
    output line_st_e         c_st
);
    fsm_e             fsm_q, fsm_d;
    logic             pw_q, pw_d;
    logic [TAG_W-1:0] pt_q, pt_d;
    logic [IDX_W-1:0] pi_q, pi_d;
    logic [TAG_W-1:0] vt_q, vt_d;
    logic             done_d;
    logic             hit;
    logic             victim_live;

    always_comb begin
        look_idx    = (fsm_q == F_IDLE) ? cpu_idx : pi_q;
        fsm_d       = fsm_q;
        pw_d        = pw_q;
        pt_d        = pt_q;
        pi_d        = pi_q;
        vt_d        = vt_q;
        done_d      = 1'b0;
        c_we        = 1'b0;
        c_idx       = look_idx;
        c_tag       = eff_tag;
        c_st        = eff_st;
        bus_valid   = 1'b0;
        bus_op      = BOP_RD;
        bus_tag     = pt_q;
        bus_idx     = pi_q;
        hit         = st_valid(eff_st) && (eff_tag == cpu_tag);
        victim_live = st_dirty(eff_st) && (eff_tag == vt_q);
        case (fsm_q)
            F_IDLE: begin
                if (cpu_valid) begin
                    pw_d = cpu_write;
                    pt_d = cpu_tag;
                    pi_d = cpu_idx;
                    if (hit && (!cpu_write || eff_st == ST_E || eff_st == ST_M)) begin
                        c_we   = 1'b1;
                        c_tag  = cpu_tag;
                        c_st   = cpu_write ? ST_M : eff_st;
                        done_d = 1'b1;
                    end else if (hit) begin
                        fsm_d = F_REQ;
                    end else if (st_dirty(eff_st)) begin
                        vt_d  = eff_tag;
                        fsm_d = F_WB;
                    end else begin
                        fsm_d = F_REQ;
                    end
                end
            end
            F_WB: begin
                bus_valid = victim_live;
                bus_op    = BOP_WB;
                bus_tag   = vt_q;
                if (!victim_live) begin
                    fsm_d = F_REQ;
                end else if (bus_gnt) begin
                    c_we  = 1'b1;
                    c_tag = vt_q;
                    c_st  = ST_I;
                    fsm_d = F_REQ;
                end
            end
            F_REQ: begin
                bus_valid = 1'b1;
                bus_op    = pw_q ? BOP_RDX : BOP_RD;
                if (bus_gnt) begin
                    c_we   = 1'b1;
                    c_tag  = pt_q;
                    c_st   = pw_q ? ST_M : (bus_shared ? ST_S : ST_E);
                    done_d = 1'b1;
                    fsm_d  = F_IDLE;
                end
            end
            default: fsm_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q    <= F_IDLE;
            pw_q     <= 1'b0;
            pt_q     <= '0;
            pi_q     <= '0;
            vt_q     <= '0;
            cpu_done <= 1'b0;
            done_st  <= ST_I;
        end else begin
            fsm_q    <= fsm_d;
            pw_q     <= pw_d;
            pt_q     <= pt_d;
            pi_q     <= pi_d;
            vt_q     <= vt_d;
            cpu_done <= done_d;
            if (done_d) done_st <= c_st;
        end
    end

    assign cpu_ready = (fsm_q == F_IDLE);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [1:0]        cpu_state,
    output logic              bus_valid,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_intervene,
    output logic              snp_writeback
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0] cpu_tag, snp_tag, a_tag, b_tag, c_tag, bus_tag;
    logic [IDX_W-1:0] cpu_idx, snp_idx, look_idx, c_idx, bus_idx;
    line_st_e         a_st, b_st, eff_st, c_st, done_st;
    snp_act_t         act;
    logic             c_we;
    bus_op_e          bus_op_w;

    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];

    mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .a_idx (snp_idx),
        .a_st  (a_st),
        .a_tag (a_tag),
        .b_idx (look_idx),
        .b_st  (b_st),
        .b_tag (b_tag),
        .s_we  (act.hit),
        .s_idx (snp_idx),
        .s_st  (act.nxt),
        .c_we  (c_we),
        .c_idx (c_idx),
        .c_tag (c_tag),
        .c_st  (c_st)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_op    (snp_op_e'(snp_op)),
        .snp_tag   (snp_tag),
        .line_st   (a_st),
        .line_tag  (a_tag),
        .act       (act)
    );

    // Snoop first: the processor side sees the post-snoop state of its line.
    assign eff_st = (act.hit && snp_idx == look_idx) ? act.nxt : b_st;

    mesi_req_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cpu_valid  (cpu_valid),
        .cpu_write  (cpu_write),
        .cpu_tag    (cpu_tag),
        .cpu_idx    (cpu_idx),
        .look_idx   (look_idx),
        .eff_st     (eff_st),
        .eff_tag    (b_tag),
        .bus_gnt    (bus_gnt),
        .bus_shared (bus_shared),
        .cpu_ready  (cpu_ready),
        .cpu_done   (cpu_done),
        .done_st    (done_st),
        .bus_valid  (bus_valid),
        .bus_op     (bus_op_w),
        .bus_tag    (bus_tag),
        .bus_idx    (bus_idx),
        .c_we       (c_we),
        .c_idx      (c_idx),
        .c_tag      (c_tag),
        .c_st       (c_st)
    );

    assign cpu_state = done_st;
    assign bus_op    = bus_op_w;
    assign bus_addr  = {bus_tag, bus_idx};

    always_ff @(posedge clk) begin
        if (rst) begin
            snp_intervene <= 1'b0;
            snp_writeback <= 1'b0;
        end else begin
            snp_intervene <= act.intervene;
            snp_writeback <= act.writeback;
        end
    end

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              bus_valid,
    input logic [1:0]        bus_op,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              snp_valid,
    input logic              snp_intervene,
    input logic              snp_writeback
);
    p_leave_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cpu_ready && !bus_valid && !cpu_done));

    p_fill_grant_done_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_gnt && bus_op != 2'd2) |=> (cpu_done && cpu_ready));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_gnt && bus_op != 2'd2) |=> (bus_valid && $stable(bus_addr) && $stable(bus_op)));

    p_intervene_has_wb_r6: assert property (@(posedge clk) disable iff (rst)
        snp_intervene |-> snp_writeback);

    p_no_snoop_no_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        !snp_valid |=> (!snp_intervene && !snp_writeback));

    p_victim_before_fill_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_gnt && bus_op == 2'd2) |=> (!cpu_done && !cpu_ready));

    p_busy_no_accept_r12: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> !cpu_ready);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_ready     (cpu_ready),
    .cpu_done      (cpu_done),
    .bus_valid     (bus_valid),
    .bus_op        (bus_op),
    .bus_addr      (bus_addr),
    .bus_gnt       (bus_gnt),
    .snp_valid     (snp_valid),
    .snp_intervene (snp_intervene),
    .snp_writeback (snp_writeback)
);

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
    localparam int AW = 10;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready, cpu_done;
    logic [1:0]    cpu_state;
    logic          bus_valid;
    logic [1:0]    bus_op;
    logic [AW-1:0] bus_addr;
    logic          bus_gnt = 1'b0, bus_shared = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = 2'd3;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_intervene, snp_writeback;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_q[$];

    always #10 clk = ~clk;

    mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(IW)) uut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_state(cpu_state),
        .bus_valid(bus_valid), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_intervene(snp_intervene), .snp_writeback(snp_writeback)
    );

    function automatic logic [AW-1:0] la(int tag, int idx);
        return {8'(tag), 2'(idx)};
    endfunction

    task automatic check(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Monitor: every completion is compared against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && cpu_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected completion", 1, 0);
            end else begin
                automatic logic [1:0] e = exp_q.pop_front();
                check(cpu_state === e, "R2 completion state", int'(cpu_state), int'(e));
            end
        end
    end

    // Driver: nbus 0 = hit, 1 = fill only, 2 = victim write-back then fill.
    task automatic cpu_op(logic wr, logic [AW-1:0] a, int nbus, logic [AW-1:0] va,
                          logic shr, logic [1:0] exp_st, string rq);
        @(negedge clk);
        check(cpu_ready === 1'b1, {rq, " ready"}, int'(cpu_ready), 1);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a;
        exp_q.push_back(exp_st);
        @(negedge clk);
        cpu_valid = 1'b0;
        if (nbus == 0) begin
            check(bus_valid === 1'b0, {rq, " no bus on hit"}, int'(bus_valid), 0);
            check(cpu_done === 1'b1, {rq, " hit done"}, int'(cpu_done), 1);
        end
        if (nbus == 2) begin
            check(bus_valid === 1'b1 && bus_op === 2'd2, {rq, " R11 write-back op"}, int'(bus_op), 2);
            check(bus_addr === va, {rq, " R11 victim addr"}, int'(bus_addr), int'(va));
            bus_gnt = 1'b1;
            @(negedge clk);
            bus_gnt = 1'b0;
            check(cpu_done === 1'b0, {rq, " R11 no done after write-back"}, int'(cpu_done), 0);
        end
        if (nbus >= 1) begin
            check(bus_valid === 1'b1, {rq, " bus request"}, int'(bus_valid), 1);
            check(bus_op === (wr ? 2'd1 : 2'd0), {rq, " bus op"}, int'(bus_op), wr ? 1 : 0);
            check(bus_addr === a, {rq, " bus addr"}, int'(bus_addr), int'(a));
            bus_gnt = 1'b1; bus_shared = shr;
            @(negedge clk);
            bus_gnt = 1'b0; bus_shared = 1'b0;
            check(cpu_done === 1'b1, {rq, " done after grant"}, int'(cpu_done), 1);
        end
    endtask

    task automatic snoop(logic [1:0] op, logic [AW-1:0] a, logic ei, logic ew, string rq);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0; snp_op = 2'd3;
        check(snp_intervene === ei, {rq, " intervene"}, int'(snp_intervene), int'(ei));
        check(snp_writeback === ew, {rq, " writeback"}, int'(snp_writeback), int'(ew));
    endtask

    initial begin : watchdog
        #(20 * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(cpu_ready === 1'b1, "R1 ready", int'(cpu_ready), 1);
        check(bus_valid === 1'b0, "R1 bus idle", int'(bus_valid), 0);
        check(cpu_done === 1'b0, "R1 done low", int'(cpu_done), 0);
        check(snp_intervene === 1'b0 && snp_writeback === 1'b0, "R1 snoop outs", int'(snp_writeback), 0);

        // R3 read miss, nobody shares -> Exclusive (2)
        cpu_op(0, la(1, 0), 1, '0, 0, 2'd2, "R3 read miss excl");
        // R5 read hit and write hit on Exclusive
        cpu_op(0, la(1, 0), 0, '0, 0, 2'd2, "R5 read hit");
        cpu_op(1, la(1, 0), 0, '0, 0, 2'd3, "R5 write hit E");
        // R3 read miss shared -> Shared (1); R4 upgrade
        cpu_op(0, la(2, 1), 1, '0, 1, 2'd1, "R3 read miss shared");
        cpu_op(1, la(2, 1), 1, '0, 0, 2'd3, "R4 upgrade from S");
        cpu_op(1, la(3, 2), 1, '0, 0, 2'd3, "R4 write miss");

        // R6 snooped read on Modified
        snoop(2'd0, la(1, 0), 1, 1, "R6 read on M");
        cpu_op(0, la(1, 0), 0, '0, 0, 2'd1, "R6 M became S");
        // R9 tag mismatch
        snoop(2'd1, la(9, 0), 0, 0, "R9 tag mismatch");
        cpu_op(0, la(1, 0), 0, '0, 0, 2'd1, "R9 line kept");
        // R6 snooped read on Exclusive
        cpu_op(0, la(5, 3), 1, '0, 0, 2'd2, "R6 setup E");
        snoop(2'd0, la(5, 3), 0, 0, "R6 read on E");
        cpu_op(0, la(5, 3), 0, '0, 0, 2'd1, "R6 E became S");
        // R7 intent-to-write on Modified
        snoop(2'd1, la(3, 2), 1, 1, "R7 rdx on M");
        cpu_op(0, la(3, 2), 1, '0, 0, 2'd2, "R7 line purged");
        // R8 plain write on clean and dirty
        snoop(2'd2, la(3, 2), 0, 0, "R8 write on E");
        cpu_op(0, la(3, 2), 1, '0, 0, 2'd2, "R8 clean purged");
        cpu_op(1, la(3, 2), 0, '0, 0, 2'd3, "R8 setup M");
        snoop(2'd2, la(3, 2), 0, 1, "R8 write on M");
        cpu_op(0, la(3, 2), 1, '0, 0, 2'd2, "R8 dirty purged");
        // R7 intent-to-write on Shared
        snoop(2'd1, la(1, 0), 0, 0, "R7 rdx on S");
        cpu_op(0, la(1, 0), 1, '0, 0, 2'd2, "R7 S purged");

        // R10 snoop and processor read on the same line, same cycle
        @(negedge clk);
        snp_valid = 1'b1; snp_op = 2'd1; snp_addr = la(1, 0);
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = la(1, 0);
        exp_q.push_back(2'd2);
        @(negedge clk);
        snp_valid = 1'b0; snp_op = 2'd3; cpu_valid = 1'b0;
        check(cpu_done === 1'b0, "R10 no hit after snoop", int'(cpu_done), 0);
        check(bus_valid === 1'b1 && bus_op === 2'd0, "R10 read miss issued", int'(bus_valid), 1);
        check(snp_writeback === 1'b0, "R10 clean line no wb", int'(snp_writeback), 0);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        check(cpu_done === 1'b1, "R10 done", int'(cpu_done), 1);

        // R11 dirty victim eviction
        cpu_op(1, la(1, 0), 0, '0, 0, 2'd3, "R11 setup M");
        cpu_op(0, la(7, 0), 2, la(1, 0), 0, 2'd2, "R11 evict");
        cpu_op(0, la(1, 0), 1, '0, 0, 2'd2, "R11 victim invalid");

        // R12 request while busy is dropped
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = la(8, 3);
        exp_q.push_back(2'd2);
        @(negedge clk);
        cpu_write = 1'b1; cpu_addr = la(5, 3);
        check(cpu_ready === 1'b0, "R12 busy", int'(cpu_ready), 0);
        @(negedge clk);
        cpu_valid = 1'b0;
        check(bus_valid === 1'b1 && bus_addr === la(8, 3), "R12 original request kept", int'(bus_addr), int'(la(8, 3)));
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        check(cpu_done === 1'b1, "R12 done", int'(cpu_done), 1);
        @(negedge clk);
        check(cpu_done === 1'b0 && bus_valid === 1'b0, "R12 dropped request silent", int'(bus_valid), 0);
        cpu_op(0, la(5, 3), 1, '0, 0, 2'd2, "R12 line replaced");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all completions seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule